// File: doc/BRIEF.md
# Short-Cycling Serial ADC Readout Controller

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. It drives an active-low chip select and a serial clock, and it reads the converter's data line. A one-cycle start request begins one sample. The controller first holds the serial clock low with chip select still high for one half-period. It then lowers chip select and produces serial clock pulses at a rate set by a system-clock divider. It captures result bits most significant first, on the rising edge of the serial clock.

Each frame has two leading clocks before the first result bit. A frame either runs to full length, with 16 or 14 serial clocks selected by a mode input, or it ends early. When it ends early, chip select rises right after the last requested bit, which cuts the conversion short. The captured bits are presented left-aligned in a 12-bit word, and every bit that was not received reads as zero. A one-cycle done strobe marks the new word.

The caller sets the sample rate by issuing starts, so the serial clock rate and the start rate are independent. A start may be issued in the same cycle as done, which gives back-to-back frames.

Top module: `sar_readout_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cs_n_o`=1, `sclk_o`=0, `done_o`=0, `busy_o`=0 and `result_o`=0.
- R2: `sclk_o` is 0 whenever `cs_n_o` is 1. `cs_n_o` falls only while `sclk_o` is 0. After a start is accepted, `cs_n_o` stays high for HALF cycles with the clock low before it falls.
- R3: Each high phase and each low phase of `sclk_o` inside a frame lasts HALF system cycles. The first low phase is counted from the fall of `cs_n_o`. A frame of N serial clocks produces `done_o` exactly 2·HALF + 2·HALF·N + 2 cycles after the cycle in which `start_i` was driven.
- R4: With `short_i`=0, a frame has 16 rising serial clock edges when `frame16_i`=1 and 14 when `frame16_i`=0, and all 12 result bits are captured.
- R5: With `short_i`=1, a frame has 2+n rising edges and captures n bits, where n is `nbits_i` clamped to the range 3..12. Values 0..2 give 3 and values 13..15 give 12. `frame16_i` has no effect in this mode.
- R6: `sdata_i` is sampled at each rising serial clock edge. Rising edges 3 through 2+n supply result bits 11 down to 12−n of `result_o`. Bits 11−n..0 are zero.
- R7: `done_o` is a one-cycle pulse in the cycle after `cs_n_o` rises. `result_o` changes only in a cycle with `done_o`=1 and holds its value until the next one.
- R8: `busy_o` is 1 from the cycle after an accepted start through the cycle in which `cs_n_o` rises, and it is 0 while `done_o` is 1. A start pulse while `busy_o`=1 has no effect on the frame length, the timing or the result.
- R9: `short_i`, `frame16_i` and `nbits_i` are captured when a start is accepted. Changing them during a frame has no effect on that frame.
- R10: A start issued in the `done_o` cycle is accepted. `cs_n_o` then stays high for exactly HALF+2 cycles between the two frames before falling again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to read one sample |
| short_i | input | 1 | 1: end the frame after the requested bit count |
| frame16_i | input | 1 | Full-frame length select: 1 gives 16 clocks, 0 gives 14 |
| nbits_i | input | 4 | Requested result bits in short mode (clamped 3..12) |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock; idles low |
| result_o | output | 12 | Captured result, left-aligned, unreceived bits zero |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| busy_o | output | 1 | A frame is in progress |

## Verification
A wrong serial-clock count or a wrong frame state shows up within one frame. The number of rising edges between the fall and rise of chip select changes, and so does the cycle on which done appears. Both are measured against the closed-form values. A wrong capture index moves bits or misses the zero fill, which shows in the left-aligned word at that frame's done. A slip in the half-period counter changes a phase width or lets chip select fall while the clock is high, and either one is caught on the serial clock edge where it happens.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_POST
  } seq_st_t;

  // requested bit count limited to the supported range
  function automatic int clamp_len(int req, int lo, int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // serial clocks in one frame for the chosen mode
  function automatic int clocks_in_frame(bit short_en, bit long_frame, int nb,
                                         int lead, int long_c, int short_c);
    if (short_en) return lead + nb;
    return long_frame ? long_c : short_c;
  endfunction

  // does rising edge number idx (1-based) carry a wanted result bit
  function automatic bit bit_in_window(int idx, int nb, int lead);
    return (idx > lead) && (idx <= lead + nb);
  endfunction

  // left-aligned position of the bit captured on rising edge idx
  function automatic int bit_pos(int idx, int lead, int res_w);
    return res_w - 1 - (idx - lead - 1);
  endfunction

endpackage

// File: rtl/sar_half_timer.sv
module sar_half_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;

  generate
    if (HALF <= 1) begin : g_direct
      assign tick_o = en_i;
    end else begin : g_count
      logic [HCW-1:0] hc_q;
      logic           last_w;

      assign last_w = (hc_q == HCW'(HALF - 1));
      assign tick_o = en_i && last_w;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hc_q <= '0;
        end else if (!en_i || last_w) begin
          hc_q <= '0;
        end else begin
          hc_q <= hc_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
  import sar_rd_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int LEAD       = 2,
  parameter int LONG_CLKS  = 16,
  parameter int SHORT_CLKS = 14,
  parameter int MIN_BITS   = 3,
  localparam int NBW = $clog2(RES_W + 1),
  localparam int CKW = $clog2(LONG_CLKS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           short_i,
  input  logic           frame16_i,
  input  logic [NBW-1:0] nbits_i,
  input  logic           tick_i,
  output logic           tmr_en_o,
  output logic           cs_n_o,
  output logic           sclk_o,
  output logic           busy_o,
  output logic           start_acc_o,
  output logic           rise_o,
  output logic [CKW-1:0] rise_idx_o,
  output logic [NBW-1:0] nb_o,
  output logic           post_o
);

  seq_st_t        st_q;
  logic [CKW-1:0] ck_idx_q;
  logic [CKW-1:0] nclk_q;
  logic [NBW-1:0] nb_q;
  logic [NBW-1:0] nb_req_w;
  logic [NBW-1:0] nb_eff_w;
  logic [CKW-1:0] nclk_w;
  logic           last_clk_w;

  // configuration decoded once, at the accepted start
  assign nb_req_w = NBW'(clamp_len(int'(nbits_i), MIN_BITS, RES_W));
  assign nb_eff_w = short_i ? nb_req_w : NBW'(RES_W);
  assign nclk_w   = CKW'(clocks_in_frame(short_i, frame16_i, int'(nb_req_w),
                                         LEAD, LONG_CLKS, SHORT_CLKS));
  assign last_clk_w = (ck_idx_q == nclk_q);

  assign start_acc_o = (st_q == ST_IDLE) && start_i;
  assign busy_o      = (st_q != ST_IDLE);
  assign post_o      = (st_q == ST_POST);
  assign tmr_en_o    = (st_q != ST_IDLE) && (st_q != ST_POST);
  assign nb_o        = nb_q;

  // rising serial edge happens at this system edge
  assign rise_o = tick_i && ((st_q == ST_SETUP) ||
                             ((st_q == ST_LOW) && !last_clk_w));
  assign rise_idx_o = (st_q == ST_SETUP) ? CKW'(1) : ck_idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cs_n_o   <= 1'b1;
      sclk_o   <= 1'b0;
      ck_idx_q <= '0;
      nclk_q   <= '0;
      nb_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cs_n_o <= 1'b1;
          sclk_o <= 1'b0;
          if (start_i) begin
            st_q     <= ST_GUARD;
            nb_q     <= nb_eff_w;
            nclk_q   <= nclk_w;
            ck_idx_q <= '0;
          end
        end
        ST_GUARD: begin
          if (tick_i) begin
            st_q   <= ST_SETUP;
            cs_n_o <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (tick_i) begin
            st_q     <= ST_HIGH;
            sclk_o   <= 1'b1;
            ck_idx_q <= CKW'(1);
          end
        end
        ST_HIGH: begin
          if (tick_i) begin
            st_q   <= ST_LOW;
            sclk_o <= 1'b0;
          end
        end
        ST_LOW: begin
          if (tick_i) begin
            if (last_clk_w) begin
              st_q   <= ST_POST;
              cs_n_o <= 1'b1;
            end else begin
              st_q     <= ST_HIGH;
              sclk_o   <= 1'b1;
              ck_idx_q <= ck_idx_q + 1'b1;
            end
          end
        end
        ST_POST: begin
          st_q <= ST_IDLE;
        end
        default: begin
          st_q   <= ST_IDLE;
          cs_n_o <= 1'b1;
          sclk_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sar_shift_capture.sv
module sar_shift_capture
  import sar_rd_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int LEAD      = 2,
  parameter int LONG_CLKS = 16,
  localparam int NBW = $clog2(RES_W + 1),
  localparam int CKW = $clog2(LONG_CLKS + 1),
  localparam int PW  = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             rise_i,
  input  logic [CKW-1:0]   rise_idx_i,
  input  logic [NBW-1:0]   nb_i,
  input  logic             sdata_i,
  input  logic             post_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  logic [RES_W-1:0] cap_q;
  logic             want_w;
  logic [PW-1:0]    pos_w;

  assign want_w = rise_i && bit_in_window(int'(rise_idx_i), int'(nb_i), LEAD);
  assign pos_w  = PW'(bit_pos(int'(rise_idx_i), LEAD, RES_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (clear_i) begin
      cap_q <= '0;
    end else if (want_w) begin
      cap_q[pos_w] <= sdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= post_i;
      if (post_i) begin
        result_o <= cap_q;
      end
    end
  end

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_rd_pkg::*;
#(
  parameter int HALF       = 2,
  parameter int RES_W      = 12,
  parameter int LEAD       = 2,
  parameter int LONG_CLKS  = 16,
  parameter int SHORT_CLKS = 14,
  parameter int MIN_BITS   = 3,
  localparam int NBW = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             frame16_i,
  input  logic [NBW-1:0]   nbits_i,
  input  logic             sdata_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int CKW = $clog2(LONG_CLKS + 1);

  // internal events, named for the checker
  logic           tick_w;
  logic           tmr_en_w;
  logic           start_acc_w;
  logic           rise_w;
  logic [CKW-1:0] rise_idx_w;
  logic [NBW-1:0] nb_w;
  logic           post_w;

  sar_half_timer #(.HALF(HALF)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (tmr_en_w),
    .tick_o (tick_w)
  );

  sar_frame_seq #(
    .RES_W      (RES_W),
    .LEAD       (LEAD),
    .LONG_CLKS  (LONG_CLKS),
    .SHORT_CLKS (SHORT_CLKS),
    .MIN_BITS   (MIN_BITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .short_i     (short_i),
    .frame16_i   (frame16_i),
    .nbits_i     (nbits_i),
    .tick_i      (tick_w),
    .tmr_en_o    (tmr_en_w),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .busy_o      (busy_o),
    .start_acc_o (start_acc_w),
    .rise_o      (rise_w),
    .rise_idx_o  (rise_idx_w),
    .nb_o        (nb_w),
    .post_o      (post_w)
  );

  sar_shift_capture #(
    .RES_W     (RES_W),
    .LEAD      (LEAD),
    .LONG_CLKS (LONG_CLKS)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_acc_w),
    .rise_i     (rise_w),
    .rise_idx_i (rise_idx_w),
    .nb_i       (nb_w),
    .sdata_i    (sdata_i),
    .post_i     (post_w),
    .result_o   (result_o),
    .done_o     (done_o)
  );

endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
  parameter int RES_W     = 12,
  parameter int LONG_CLKS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             done_o,
  input logic             busy_o,
  input logic [RES_W-1:0] result_o,
  input logic             rise_w
);
  localparam int RCW = $clog2(LONG_CLKS + 2);

  logic [RCW-1:0] rises_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rises_q <= '0;
    else if (cs_n_o) rises_q <= '0;
    else if (rise_w) rises_q <= rises_q + 1'b1;
  end

  a_r2_cs_fall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !sclk_o);

  a_r2_clk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  a_r7_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> done_o);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !busy_o));

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);

  a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r4_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> (rises_q <= RCW'(LONG_CLKS)));

endmodule

bind sar_readout_ctrl sar_readout_chk #(
  .RES_W     (RES_W),
  .LONG_CLKS (LONG_CLKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .cs_n_o   (cs_n_o),
  .sclk_o   (sclk_o),
  .done_o   (done_o),
  .busy_o   (busy_o),
  .result_o (result_o),
  .rise_w   (rise_w)
);

// File: tb/sim_sar_readout_ctrl.sv
`timescale 1ns/1ps
module sim_sar_readout_ctrl;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        short_i = 1'b0;
  logic        frame16_i = 1'b1;
  logic [3:0]  nbits_i = 4'd12;
  logic        sdata_i = 1'b0;
  logic        cs_n_o, sclk_o, done_o, busy_o;
  logic [11:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sar_readout_ctrl #(.HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_i),
    .frame16_i(frame16_i), .nbits_i(nbits_i), .sdata_i(sdata_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  // converter model and edge monitors
  logic [11:0] adc_val = 12'h000;
  int cyc = 0, rise_cnt = 0, fall_cnt = 0;
  int t_rise = 0, t_low_ref = 0, t_cs_rise = 0, last_gap = 0;
  int bad_fall = 0, bad_idle = 0, bad_width = 0;

  always @(posedge clk) cyc++;

  always @(negedge cs_n_o) begin
    fall_cnt = 0; rise_cnt = 0; t_low_ref = cyc; sdata_i = 1'b0;
    if (sclk_o !== 1'b0) bad_fall++;
    last_gap = cyc - t_cs_rise;
  end

  always @(posedge cs_n_o) t_cs_rise = cyc;

  always @(posedge sclk_o) begin
    if (cs_n_o === 1'b1) bad_idle++;
    rise_cnt++;
    t_rise = cyc;
    if (cyc - t_low_ref != HALF) bad_width++;
  end

  always @(negedge sclk_o) begin
    if (cs_n_o === 1'b0) begin
      fall_cnt++;
      sdata_i = (fall_cnt >= 2 && fall_cnt <= 13) ? adc_val[13-fall_cnt] : 1'b0;
      if (cyc - t_rise != HALF) bad_width++;
      t_low_ref = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode: 0 plain, 1 extra start mid-frame, 2 config change mid-frame
  task automatic run_frame(input bit sh, input bit f16, input int nb_in,
                           input logic [11:0] val, input int mode,
                           input bit tight, input string tag);
    int n_eff, nclk, exp_cyc, n;
    logic [11:0] exp_res;
    bit saw_busy;
    n_eff   = sh ? ((nb_in < 3) ? 3 : (nb_in > 12) ? 12 : nb_in) : 12;
    nclk    = sh ? 2 + n_eff : (f16 ? 16 : 14);
    exp_cyc = 2*HALF + 2*HALF*nclk + 2;
    exp_res = val & (12'hFFF << (12 - n_eff));
    short_i = sh; frame16_i = f16; nbits_i = 4'(nb_in); adc_val = val;
    start_i = 1'b1;
    n = 0; saw_busy = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      start_i = 1'b0;
      if (busy_o) saw_busy = 1;
      if (n == 20 && mode == 1) start_i = 1'b1;
      if (n == 20 && mode == 2) begin
        short_i = ~sh; frame16_i = ~f16; nbits_i = 4'd3;
      end
    end while (!done_o && n < 5000);
    chk(n == exp_cyc, {tag, " R3 done timing"}, n, exp_cyc);
    chk(rise_cnt == nclk, {tag, sh ? " R5 clocks" : " R4 clocks"}, rise_cnt, nclk);
    chk(result_o == exp_res, {tag, " R6 result"}, result_o, exp_res);
    chk(saw_busy && !busy_o, {tag, " R8 busy"}, busy_o, 0);
    if (!tight) begin
      @(negedge clk);
      chk(done_o == 1'b0, {tag, " R7 done width"}, done_o, 0);
      chk(result_o == exp_res, {tag, " R7 result hold"}, result_o, exp_res);
    end
  endtask

  task automatic t_reset();
    // R1: state while reset is held and just after release
    chk(cs_n_o == 1 && sclk_o == 0, "R1 pins in reset", {cs_n_o, sclk_o}, 2'b10);
    chk(done_o == 0 && busy_o == 0 && result_o == 0, "R1 flags in reset",
        {done_o, busy_o, result_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n_o == 1 && sclk_o == 0 && !busy_o, "R1 after release",
        {cs_n_o, sclk_o, busy_o}, 3'b100);
  endtask

  task automatic t_burst();
    // R10: start in the done cycle, chip select returns high between frames
    run_frame(1, 0, 8, 12'h5A3, 0, 1, "burst-a");
    run_frame(1, 0, 8, 12'hC3F, 0, 0, "burst-b R10");
    chk(last_gap == HALF + 2, "R10 cs high gap", last_gap, HALF + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (2) @(negedge clk);
    run_frame(0, 1, 0,  12'hA5C, 0, 0, "full16");      // R4 R6
    run_frame(0, 0, 0,  12'h3C9, 0, 0, "full14");      // R4
    run_frame(1, 1, 8,  12'hFFF, 0, 0, "short8");      // R5 R6
    run_frame(1, 0, 3,  12'hB71, 0, 0, "short3");      // R5
    run_frame(1, 1, 1,  12'hE00, 0, 0, "clamp-lo");    // R5 clamp
    run_frame(1, 0, 15, 12'h9D6, 0, 0, "clamp-hi");    // R5 clamp
    run_frame(0, 1, 0,  12'h1E7, 1, 0, "start-busy");  // R8 ignored start
    run_frame(0, 1, 5,  12'h6B2, 2, 0, "cfg-change");  // R9
    t_burst();
    chk(bad_fall == 0, "R2 cs fell with sclk high", bad_fall, 0);
    chk(bad_idle == 0, "R2 sclk high while cs high", bad_idle, 0);
    chk(bad_width == 0, "R3 sclk phase width", bad_width, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule